// File: doc/BRIEF.md
# Criticality-Aware Two-Thread Issue Arbiter

This block divides the two issue slots of a two-wide, two-thread in-order core between threads that belong to the same parallel program. Each thread decodes special progress-marker instructions at fixed points of its loop body. The block keeps one progress counter for each thread. After every ten markers, counted across both threads, it compares the two counters. If the gap between them is larger than a programmable threshold, the thread that is behind is named critical. If the gap is not larger, the critical mark is withdrawn.

Each cycle the block takes the number of ready instructions offered by each thread and returns the number of slots granted to each thread. With no critical thread named, the split is fair. When a critical thread is named, that thread may take both slots whenever it can fill them. The grants are registered, so they leave the block one clock after the ready counts are sampled.

Top module: `crit_issue_arb`

## Requirements
- R1: While reset is held and on the first cycle after it, both grants are 0 and `crit_valid` is 0.
- R2: With no critical thread, if both ready counts are non-zero, each thread is granted exactly 1 slot.
- R3: If only one thread has a non-zero ready count, that thread is granted its ready count and the other thread is granted 0. A ready count is 0, 1 or 2; the code 3 is treated as 2. If neither thread is ready, both grants are 0.
- R4: `mp_dec[0]` and `mp_dec[1]` each increment their own thread's counter, and both may be set in one cycle. A comparison happens on the clock edge that registers the tenth marker since the previous comparison, counting markers from both threads together. When two markers arrive in one cycle and cross the tenth, the extra marker counts toward the next window.
- R5: At a comparison, the counters include that cycle's markers. If the absolute difference is strictly greater than `delta`, `crit_valid` becomes 1 and `crit_id` names the thread with the lower count (0 or 1). This update takes effect at that same edge.
- R6: At a comparison where the difference is less than or equal to `delta`, `crit_valid` becomes 0. Between comparisons, `crit_valid` and `crit_id` do not change.
- R7: When a critical thread is named and its ready count is 2, it is granted 2 slots and the other thread is granted 0, whatever the other thread's readiness.
- R8: When a critical thread is named and its ready count is below 2, the grants follow the fair rules of R2 and R3.
- R9: Each grant is no larger than its thread's ready count, and the two grants never sum to more than 2.
- R10: Grants are registered. The grants visible after a clock edge are computed from the ready counts sampled at that edge and from the critical state held just before it.
- R11: `delta` is used only at comparison edges. A change to `delta` between comparisons has no effect on `crit_valid` or `crit_id`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mp_dec | input | 2 | Progress marker decoded this cycle; bit n is thread n |
| delta | input | DELTA_W | Imbalance threshold, sampled at comparison edges |
| rdy0 | input | 2 | Ready instruction count of thread 0 |
| rdy1 | input | 2 | Ready instruction count of thread 1 |
| grant0 | output | 2 | Issue slots granted to thread 0 |
| grant1 | output | 2 | Issue slots granted to thread 1 |
| crit_valid | output | 1 | A critical thread is currently named |
| crit_id | output | 1 | Index of the critical thread |

## Verification
The bench builds the block with CNT_W=16, WINDOW=10 and DELTA_W=4. A window of ten lets the tests reach several comparison points within a few dozen marker cycles. With 16-bit counters, no test gets near counter wrap. The 4-bit threshold lets a test set `delta` to 0, to an exact-equality value and to 15, which covers the strictly-greater boundary as well as a threshold that withdraws the mark. The tests also place a double-marker cycle across a window boundary, so the carried-over marker moves the next comparison earlier by one.

// File: rtl/cia_pkg.sv
package cia_pkg;
  typedef logic [1:0] slot_t;

  function automatic slot_t clamp2(input slot_t r);
    return (r == 2'd3) ? 2'd2 : r;
  endfunction
endpackage

// File: rtl/crit_detect.sv
module crit_detect #(
  parameter int CNT_W   = 16,
  parameter int WINDOW  = 10,
  parameter int DELTA_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         mp_dec,
  input  logic [DELTA_W-1:0] delta,
  output logic               crit_valid,
  output logic               crit_id
);
  localparam int WIN_W = $clog2(WINDOW + 2);

  logic [CNT_W-1:0] cnt   [2];
  logic [CNT_W-1:0] cnt_n [2];

  for (genvar t = 0; t < 2; t++) begin : g_thr
    assign cnt_n[t] = cnt[t] + CNT_W'(mp_dec[t]);
    always_ff @(posedge clk) begin
      if (rst) cnt[t] <= '0;
      else     cnt[t] <= cnt_n[t];
    end
  end

  logic [WIN_W-1:0] win, win_sum;
  logic             fire;
  logic [CNT_W-1:0] gap;
  logic             over;

  assign win_sum = win + WIN_W'(mp_dec[0]) + WIN_W'(mp_dec[1]);
  assign fire    = (win_sum >= WIN_W'(WINDOW));
  assign gap     = (cnt_n[0] > cnt_n[1]) ? cnt_n[0] - cnt_n[1] : cnt_n[1] - cnt_n[0];
  assign over    = (gap > CNT_W'(delta));

  always_ff @(posedge clk) begin
    if (rst) begin
      win        <= '0;
      crit_valid <= 1'b0;
      crit_id    <= 1'b0;
    end else begin
      win <= fire ? win_sum - WIN_W'(WINDOW) : win_sum;
      if (fire) begin
        crit_valid <= over;
        crit_id    <= (cnt_n[1] < cnt_n[0]);
      end
    end
  end

  // R6 / R11: the critical state only moves at a comparison edge
  a_r6_hold_between: assert property (@(posedge clk) disable iff (rst)
    !fire |=> ($stable(crit_valid) && $stable(crit_id)));
  // R4: the window counter stays below its limit
  a_r4_window_bound: assert property (@(posedge clk) disable iff (rst)
    win < WIN_W'(WINDOW));
endmodule

// File: rtl/issue_policy.sv
module issue_policy
  import cia_pkg::*;
(
  input  slot_t rdy0,
  input  slot_t rdy1,
  input  logic  crit_valid,
  input  logic  crit_id,
  output slot_t g0,
  output slot_t g1
);
  slot_t r0, r1;
  assign r0 = clamp2(rdy0);
  assign r1 = clamp2(rdy1);

  always_comb begin
    if (crit_valid && !crit_id && r0 == 2'd2) begin
      g0 = 2'd2; g1 = 2'd0;
    end else if (crit_valid && crit_id && r1 == 2'd2) begin
      g0 = 2'd0; g1 = 2'd2;
    end else if (r0 != 2'd0 && r1 != 2'd0) begin
      g0 = 2'd1; g1 = 2'd1;
    end else begin
      g0 = r0;   g1 = r1;
    end
  end
endmodule

// File: rtl/crit_issue_arb.sv
module crit_issue_arb
  import cia_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int WINDOW  = 10,
  parameter int DELTA_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         mp_dec,
  input  logic [DELTA_W-1:0] delta,
  input  logic [1:0]         rdy0,
  input  logic [1:0]         rdy1,
  output logic [1:0]         grant0,
  output logic [1:0]         grant1,
  output logic               crit_valid,
  output logic               crit_id
);
  slot_t g0_c, g1_c;

  crit_detect #(.CNT_W(CNT_W), .WINDOW(WINDOW), .DELTA_W(DELTA_W)) i_detect (
    .clk(clk), .rst(rst), .mp_dec(mp_dec), .delta(delta),
    .crit_valid(crit_valid), .crit_id(crit_id)
  );

  issue_policy i_policy (
    .rdy0(rdy0), .rdy1(rdy1), .crit_valid(crit_valid), .crit_id(crit_id),
    .g0(g0_c), .g1(g1_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      grant0 <= '0;
      grant1 <= '0;
    end else begin
      grant0 <= g0_c;
      grant1 <= g1_c;
    end
  end

  // R9: total bandwidth is two
  a_r9_sum_le2: assert property (@(posedge clk) disable iff (rst)
    (3'(grant0) + 3'(grant1)) <= 3'd2);
  // R9: no grant beyond what was ready
  a_r9_le_ready: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (grant0 <= clamp2($past(rdy0)) && grant1 <= clamp2($past(rdy1))));
  // R7: a critical thread with two ready takes both slots
  a_r7_crit_both: assert property (@(posedge clk) disable iff (rst)
    (crit_valid && crit_id && rdy1 >= 2'd2) |=> (grant1 == 2'd2 && grant0 == 2'd0));
  // R2: fair split without a critical thread
  a_r2_fair_split: assert property (@(posedge clk) disable iff (rst)
    (!crit_valid && rdy0 != 2'd0 && rdy1 != 2'd0) |=> (grant0 == 2'd1 && grant1 == 2'd1));
endmodule

// File: tb/test_crit_issue_arb.sv
module test_crit_issue_arb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mp_dec = 2'b00;
  logic [3:0] delta = 4'd0;
  logic [1:0] rdy0 = 2'd0, rdy1 = 2'd0;
  logic [1:0] grant0, grant1;
  logic       crit_valid, crit_id;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  crit_issue_arb #(.CNT_W(16), .WINDOW(10), .DELTA_W(4)) i_crit_issue_arb (
    .clk(clk), .rst(rst), .mp_dec(mp_dec), .delta(delta), .rdy0(rdy0), .rdy1(rdy1),
    .grant0(grant0), .grant1(grant1), .crit_valid(crit_valid), .crit_id(crit_id)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic marker(input logic [1:0] m);
    @(negedge clk); mp_dec = m;
    @(posedge clk); #1; mp_dec = 2'b00;
  endtask

  task automatic grant_case(input string req, input int r0, input int r1, input int e0, input int e1);
    @(negedge clk); rdy0 = 2'(r0); rdy1 = 2'(r1);
    @(posedge clk); #1;
    chk({req, " grant0"}, grant0, e0);
    chk({req, " grant1"}, grant1, e1);
    rdy0 = 2'd0; rdy1 = 2'd0;
  endtask

  task automatic t_reset;
    @(posedge clk); #1;
    chk("R1 grant0 in reset", grant0, 0);
    chk("R1 crit_valid in reset", crit_valid, 0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    chk("R1 grant1 after reset", grant1, 0);
    chk("R1 crit_valid after reset", crit_valid, 0);
  endtask

  task automatic t_fair;
    grant_case("R2 both 1/2", 1, 2, 1, 1);
    grant_case("R2 both 2/2", 2, 2, 1, 1);
    grant_case("R3 only t0 two", 2, 0, 2, 0);
    grant_case("R3 only t1 one", 0, 1, 0, 1);
    grant_case("R3 none", 0, 0, 0, 0);
    grant_case("R3 code3 as two", 3, 0, 2, 0);
    grant_case("R10 registered", 0, 2, 0, 2);
  endtask

  task automatic t_detect_t1;
    delta = 4'd2;
    for (int i = 0; i < 7; i++) marker(2'b01);
    for (int i = 0; i < 2; i++) marker(2'b10);
    chk("R4 no compare at nine", crit_valid, 0);
    marker(2'b10); // counts 7,3 gap 4 > 2
    chk("R5 crit_valid", crit_valid, 1);
    chk("R5 crit_id lower", crit_id, 1);
    grant_case("R7 crit t1 takes both", 2, 2, 0, 2);
    grant_case("R8 crit t1 has one", 1, 1, 1, 1);
    grant_case("R8 crit t1 one, other two", 2, 1, 1, 1);
    grant_case("R8 crit t1 one, other none", 0, 1, 0, 1);
  endtask

  task automatic t_clear;
    @(negedge clk); delta = 4'd15;
    @(posedge clk); #1;
    chk("R11 delta change no effect", crit_valid, 1);
    for (int i = 0; i < 4; i++) marker(2'b11);
    chk("R6 hold between compares", crit_valid, 1);
    marker(2'b11); // counts 12,8 gap 4 <= 15
    chk("R6 cleared", crit_valid, 0);
  endtask

  task automatic t_detect_t0;
    delta = 4'd0;
    for (int i = 0; i < 10; i++) marker(2'b10); // 12,18
    chk("R5 crit_valid t0", crit_valid, 1);
    chk("R5 crit_id t0", crit_id, 0);
    grant_case("R7 crit t0 takes both", 2, 2, 2, 0);
    delta = 4'd6;
    for (int i = 0; i < 5; i++) marker(2'b11); // 17,23 gap 6 == 6
    chk("R6 equal gap clears", crit_valid, 0);
  endtask

  task automatic t_carry;
    delta = 4'd1;
    for (int i = 0; i < 9; i++) marker(2'b01); // 26,23 window 9
    chk("R4 window at nine", crit_valid, 0);
    marker(2'b11); // 27,24 gap 3, window carries 1
    chk("R4 double crossing compares", crit_valid, 1);
    chk("R5 id after double", crit_id, 1);
    for (int i = 0; i < 8; i++) marker(2'b10); // 27,32 window 9
    chk("R4 carry no early compare", crit_id, 1);
    marker(2'b01); // 28,32 gap 4
    chk("R4 carry compare at tenth", crit_id, 0);
    chk("R5 valid after carry", crit_valid, 1);
  endtask

  initial begin
    #4000000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset;
    t_fair;
    t_detect_t1;
    t_clear;
    t_detect_t0;
    t_carry;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule